// File: doc/BRIEF.md
# Interleaved I/Q Word Demultiplexer

This block accepts a single stream of 14-bit samples in which in-phase and quadrature words take turns, one word on every rising edge of a fast clock that runs at twice the output sample rate. It divides that clock by two to form a sample enable. It collects each I word together with the Q word that follows it, and presents the two side by side with a one-cycle valid strobe at every pair boundary.

The phase of the divide-by-two is set by an I/Q marker input. Any word that arrives while the marker is high is taken as an I word. The marker may toggle on every I slot or may be a single pulse, and the divider keeps the phase it was given. A rising edge on the synchronisation input produces a reset pulse for the downstream processing. This pulse always starts at the next pair boundary, so its timing is the same whichever slot the edge fell in. The block also provides a data-rate enable that toggles on every fast cycle, for the upstream source.

There is no elastic storage on the path. The delay from a Q word to its paired output is fixed at one register stage.

Top module: `iq_deinterleaver`

## Requirements
- R1: While `rst` is high at a clock edge, every output register is cleared: `i_word`, `q_word`, `pair_valid`, `sample_en`, `proc_rst` and `src_rate_en` all read 0.
- R2: With no marker, the first word captured after reset is an I word and later words alternate I, Q, I, Q. After the edge that captures a Q word, `i_word` holds the preceding I word and `q_word` holds that Q word, and `pair_valid` is 1 for that one cycle.
- R3: `sample_en` is 1 in the cycle after each edge that captures a Q word and 0 otherwise, so it is never high in two consecutive cycles. `pair_valid` is never 1 while `sample_en` is 0.
- R4: A word captured while `iq_mark` is 1 is an I word. The word after it is its Q partner. After a single marker pulse, the new phase is held with no further marker.
- R5: If the marker falls on a word that would have been a Q word, the divider realigns at once. The I word held before it is dropped, and neither `pair_valid` nor `sample_en` is raised in the following cycle.
- R6: A marker that repeats on every I slot leaves the phase, the pairs and the strobes unchanged.
- R7: A 0-to-1 change of `sync_in` seen on an I-slot word raises `proc_rst` for exactly the two cycles that start with the next `pair_valid`/`sample_en` cycle.
- R8: An edge seen on a Q-slot word gives `proc_rst` in the two cycles after that Q word is captured, which is the same boundary as an edge on the I word just before it. A level held high across both slots gives a single pulse.
- R9: Holding `sync_in` high gives no pulse after the first one. A level that is already high while `rst` is asserted gives no pulse after reset ends.
- R10: `src_rate_en` is 1 in the first cycle after reset ends and inverts on every fast clock edge after that.
- R11: `i_word` and `q_word` change only in the cycles where `pair_valid` is 1. Between strobes they hold their last pair, or 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast word clock, twice the output sample rate |
| rst | input | 1 | Synchronous reset, active high |
| word_in | input | SAMPLE_W (14) | Interleaved I/Q sample word |
| iq_mark | input | 1 | High to mark the current word as an I word |
| sync_in | input | 1 | A rising edge requests a processing reset |
| i_word | output | SAMPLE_W (14) | In-phase word of the latest pair |
| q_word | output | SAMPLE_W (14) | Quadrature word of the latest pair |
| pair_valid | output | 1 | One-cycle strobe when a new pair is presented |
| sample_en | output | 1 | Half-rate sample enable, high at each pair boundary |
| proc_rst | output | 1 | Two-cycle reset pulse for downstream processing |
| src_rate_en | output | 1 | Data-rate enable for the upstream source, toggles every cycle |

## Verification
The assertions take it for granted that `iq_mark` and `sync_in` are synchronous levels, sampled once per fast cycle. They also assume the marker is raised only on words meant to start a pair, and that reset is held for at least one edge. The stimulus drives every input on the falling edge, so each word has exactly one marker and sync value. It places markers only on chosen words: a lone realigning pulse, a run on I slots, and a second realignment. It shapes sync as lone I-slot and Q-slot pulses, a two-slot pulse, a long held level, and a level already high through reset.

// File: rtl/iqdm_pkg.sv
package iqdm_pkg;

    // Slot the divider expects for the next incoming word.
    typedef enum logic {
        SLOT_I = 1'b0,
        SLOT_Q = 1'b1
    } slot_e;

    // Per-word classification, shared by the capture and sync logic.
    typedef struct packed {
        logic is_i;          // word is the first of a pair
        logic closes_pair;   // word is the second of a pair (boundary)
    } slot_info_t;

    // Fast cycles in one output sample period.
    localparam int unsigned WORDS_PER_SAMPLE = 2;

    // A marker forces I; otherwise follow the expected slot.
    function automatic logic word_is_i(input slot_e expected, input logic mark);
        return mark || (expected == SLOT_I);
    endfunction

    function automatic slot_e slot_after(input logic cur_is_i);
        return cur_is_i ? SLOT_Q : SLOT_I;
    endfunction

endpackage

// File: rtl/iqdm_phase_ctrl.sv
module iqdm_phase_ctrl
    import iqdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mark,
    output slot_info_t info,
    output logic       sample_en,
    output logic       rate_en
);

    slot_e expect_slot;

    // Classify the word on the input this cycle.
    always_comb begin
        info.is_i        = word_is_i(expect_slot, mark);
        info.closes_pair = !info.is_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            expect_slot <= SLOT_I;
            sample_en   <= 1'b0;
            rate_en     <= 1'b0;
        end else begin
            expect_slot <= slot_after(info.is_i);
            sample_en   <= info.closes_pair;
            rate_en     <= ~rate_en;
        end
    end

endmodule

// File: rtl/iqdm_pair_capture.sv
module iqdm_pair_capture
    import iqdm_pkg::*;
#(
    parameter int unsigned W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  slot_info_t   info,
    output logic [W-1:0] i_out,
    output logic [W-1:0] q_out,
    output logic         pair_valid
);

    logic [W-1:0] i_hold;
    logic         i_held;

    always_ff @(posedge clk) begin
        if (rst) begin
            i_hold     <= '0;
            i_held     <= 1'b0;
            i_out      <= '0;
            q_out      <= '0;
            pair_valid <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            if (info.is_i) begin
                // A fresh I word overwrites any half-built pair.
                i_hold <= din;
                i_held <= 1'b1;
            end
            if (info.closes_pair) begin
                i_held <= 1'b0;
                if (i_held) begin
                    i_out      <= i_hold;
                    q_out      <= din;
                    pair_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/iqdm_sync_pulse.sv
module iqdm_sync_pulse
    import iqdm_pkg::*;
#(
    parameter int unsigned PULSE_LEN = WORDS_PER_SAMPLE
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    input  logic at_boundary,
    output logic proc_rst
);

    localparam int unsigned CW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(PULSE_LEN - 1);

    logic          sync_prev;
    logic          pending;
    logic [CW-1:0] remain;
    logic          rise;

    assign rise = sync_in && !sync_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_prev <= 1'b1;   // a level held through reset is not an edge
            pending   <= 1'b0;
            remain    <= '0;
            proc_rst  <= 1'b0;
        end else begin
            sync_prev <= sync_in;
            if (at_boundary && (pending || rise)) begin
                pending  <= 1'b0;
                proc_rst <= 1'b1;
                remain   <= LAST;
            end else begin
                pending <= pending || rise;
                if (remain != '0) begin
                    remain   <= remain - 1'b1;
                    proc_rst <= 1'b1;
                end else begin
                    proc_rst <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/iq_deinterleaver.sv
module iq_deinterleaver
    import iqdm_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 14
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] word_in,
    input  logic                iq_mark,
    input  logic                sync_in,
    output logic [SAMPLE_W-1:0] i_word,
    output logic [SAMPLE_W-1:0] q_word,
    output logic                pair_valid,
    output logic                sample_en,
    output logic                proc_rst,
    output logic                src_rate_en
);

    slot_info_t info;

    iqdm_phase_ctrl u_phase (
        .clk       (clk),
        .rst       (rst),
        .mark      (iq_mark),
        .info      (info),
        .sample_en (sample_en),
        .rate_en   (src_rate_en)
    );

    iqdm_pair_capture #(.W(SAMPLE_W)) u_capture (
        .clk        (clk),
        .rst        (rst),
        .din        (word_in),
        .info       (info),
        .i_out      (i_word),
        .q_out      (q_word),
        .pair_valid (pair_valid)
    );

    iqdm_sync_pulse #(.PULSE_LEN(WORDS_PER_SAMPLE)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .sync_in     (sync_in),
        .at_boundary (info.closes_pair),
        .proc_rst    (proc_rst)
    );

endmodule

// File: rtl/iq_deinterleaver_chk.sv
module iq_deinterleaver_chk #(
    parameter int unsigned SAMPLE_W = 14
) (
    input logic                clk,
    input logic                rst,
    input logic                iq_mark,
    input logic [SAMPLE_W-1:0] i_word,
    input logic [SAMPLE_W-1:0] q_word,
    input logic                pair_valid,
    input logic                sample_en,
    input logic                proc_rst,
    input logic                src_rate_en
);

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    a_r3_valid_needs_en: assert property (@(posedge clk) disable iff (rst)
        pair_valid |-> sample_en);

    a_r3_en_alternates: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> !sample_en);

    a_r4_marked_word_is_i: assert property (@(posedge clk) disable iff (rst)
        iq_mark |=> (!sample_en && !pair_valid));

    a_r7_pulse_at_boundary: assert property (@(posedge clk) disable iff (rst)
        $rose(proc_rst) |-> sample_en);

    a_r7_pulse_two_cycles: assert property (@(posedge clk) disable iff (rst)
        $rose(proc_rst) |=> proc_rst);

    a_r10_rate_toggles: assert property (@(posedge clk) disable iff (rst)
        armed |-> (src_rate_en != $past(src_rate_en)));

    a_r11_words_hold: assert property (@(posedge clk) disable iff (rst)
        !pair_valid |-> ($stable(i_word) && $stable(q_word)));

endmodule

bind iq_deinterleaver iq_deinterleaver_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .iq_mark     (iq_mark),
    .i_word      (i_word),
    .q_word      (q_word),
    .pair_valid  (pair_valid),
    .sample_en   (sample_en),
    .proc_rst    (proc_rst),
    .src_rate_en (src_rate_en)
);

// File: tb/iq_deinterleaver_bench.sv
module iq_deinterleaver_bench;

    localparam int W = 14;
    localparam int N = 130;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] word_in;
    logic         iq_mark;
    logic         sync_in;
    logic [W-1:0] i_word, q_word;
    logic         pair_valid, sample_en, proc_rst, src_rate_en;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    iq_deinterleaver #(.SAMPLE_W(W)) u_iq_deinterleaver (
        .clk         (clk),
        .rst         (rst),
        .word_in     (word_in),
        .iq_mark     (iq_mark),
        .sync_in     (sync_in),
        .i_word      (i_word),
        .q_word      (q_word),
        .pair_valid  (pair_valid),
        .sample_en   (sample_en),
        .proc_rst    (proc_rst),
        .src_rate_en (src_rate_en)
    );

    function automatic logic [W-1:0] word_at(input int g);
        return W'((g * 613 + 9) % (1 << W));
    endfunction

    // Markers: lone realign on a Q slot (21), a run on I slots, a second realign (100).
    function automatic logic mark_at(input int g);
        return (g == 21) || (g >= 40 && g < 80 && ((g - 21) % 2 == 0)) || (g == 100);
    endfunction

    // Sync: high through reset, I-slot pulse, Q-slot pulse, both slots, held level, late Q pulse.
    function automatic logic sync_at(input int g);
        return (g < 3) || (g == 6) || (g == 11) || (g == 14) || (g == 15) ||
               (g >= 30 && g < 46) || (g == 121);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_cleared(input string tag);
        check("R1", {tag, " i_word"}, int'(i_word), 0);
        check("R1", {tag, " q_word"}, int'(q_word), 0);
        check("R1", {tag, " pair_valid"}, int'(pair_valid), 0);
        check("R1", {tag, " sample_en"}, int'(sample_en), 0);
        check("R1", {tag, " proc_rst"}, int'(proc_rst), 0);
        check("R1", {tag, " src_rate_en"}, int'(src_rate_en), 0);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int phase0  = 0;
        int rleft   = 0;
        bit pend    = 0;
        bit s_prev  = 1;
        int exp_i   = 0;
        int exp_q   = 0;

        rst     = 1'b1;
        word_in = '0;
        iq_mark = 1'b0;
        sync_in = 1'b1;   // R9: level already high during reset
        repeat (3) @(posedge clk);
        #2;
        check_cleared("reset");

        for (int g = 0; g < N; g++) begin
            bit is_q, rise;
            @(negedge clk);
            rst     = 1'b0;
            word_in = word_at(g);
            iq_mark = mark_at(g);
            sync_in = sync_at(g);
            @(posedge clk);
            #2;

            if (mark_at(g)) phase0 = g;          // R4, R5: marked word starts a pair
            is_q = ((g - phase0) % 2) == 1;
            rise = sync_at(g) && !s_prev;
            s_prev = sync_at(g);
            if (is_q && (pend || rise)) begin
                rleft = 2;
                pend  = 0;
            end else begin
                pend = pend || rise;
            end
            if (is_q) begin
                exp_i = int'(word_at(g - 1));
                exp_q = int'(word_at(g));
            end

            check("R2", $sformatf("pair_valid word %0d", g), int'(pair_valid), int'(is_q));
            check("R3", $sformatf("sample_en word %0d", g), int'(sample_en), int'(is_q));
            check("R11", $sformatf("i_word word %0d", g), int'(i_word), exp_i);
            check("R11", $sformatf("q_word word %0d", g), int'(q_word), exp_q);
            check("R10", $sformatf("src_rate_en word %0d", g), int'(src_rate_en), int'(g % 2 == 0));
            // R7 (I-slot edges 6, 14), R8 (Q-slot edges 11, 30, 121), R9 (held and reset level)
            check("R7_R8_R9", $sformatf("proc_rst word %0d", g), int'(proc_rst), int'(rleft > 0));
            if (rleft > 0) rleft--;
            if (g == 21 || g == 100)
                check("R5", $sformatf("no strobe on realign word %0d", g),
                      int'(pair_valid || sample_en), 0);
            if (g >= 40 && g < 80 && mark_at(g))
                check("R6", $sformatf("periodic mark word %0d keeps phase", g),
                      int'(sample_en), 0);
        end

        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        check_cleared("late reset");

        summary();
    end

endmodule